// File: doc/BRIEF.md
# Write-Once Snooping Coherence Line Controller

This block tracks the coherence state of one line in a private cache that sits on a shared snooping bus. It uses a write-once policy. The first processor write to a clean, possibly shared line is sent through to memory, and every other cached copy is invalidated. After that write the line is the only cached copy and is still clean. Any further write stays in the cache, and memory then holds stale data. The controller takes processor requests (read, write, evict). It works out hit or miss from the line's own state, starts at most one bus transaction at a time, and holds the processor off until that transaction completes. It also watches transactions from other caches and lowers the line's state as they require. When another cache asks for a line held modified, it raises a flag so that this cache supplies the data.

The controller has four states: IDLE, ISSUE, THRU and ACK. In IDLE it accepts a request, but only in a cycle with no snoop. A request that needs no bus is finished at once and goes to ACK. A request that needs the bus goes to ISSUE. ISSUE drives the bus command that the current line state calls for. On completion it goes to ACK, or to THRU for the second step of a first write. If a snoop has made the bus unnecessary, ISSUE goes to ACK without a bus transaction. THRU drives the write-through. If the line has been snooped away, THRU falls back to ISSUE. ACK raises the processor ready signal for one cycle and then returns to IDLE.

Top module: `wo_coherence_ctrl`

## Requirements

**Encodings**

| Field | Code | Meaning |
|---|---|---|
| line state | 0 | Invalid |
| line state | 1 | Valid (clean, may be shared) |
| line state | 2 | Reserved (clean, sole copy, written once) |
| line state | 3 | Dirty (sole copy, memory stale) |
| processor op | 0 | read |
| processor op | 1 | write |
| processor op | 2 | evict |
| bus and snoop command | 0 | read-miss |
| bus and snoop command | 1 | write-miss |
| bus and snoop command | 2 | invalidate |
| bus and snoop command | 3 | write-through |
| bus and snoop command | 4 | write-back |

**Requirements**

- R1: After reset the line state is Invalid (0), and neither `bus_req` nor `cpu_ready` is asserted.
- R2: A read to a line in any state other than Invalid completes with no bus transaction, and the line state does not change.
- R3: A read to an Invalid line issues one read-miss (0) and leaves the line Valid (1).
- R4: A snooped read-miss that finds the line Dirty asserts `snp_supply` in that same cycle and moves the line to Valid.
- R5: A write to a Valid line issues an invalidate (2) and then a write-through (3), in that order, and leaves the line Reserved (2).
- R6: A write to a Reserved or Dirty line completes with no bus transaction and leaves the line Dirty (3).
- R7: A write to an Invalid line issues one write-miss (1) and leaves the line Dirty.
- R8: Evicting a Dirty line issues one write-back (4) and then leaves the line Invalid. Evicting a line in any other state issues nothing and leaves it Invalid.
- R9: A snooped invalidate, write-miss or write-through moves the line to Invalid from any state. A snooped write-miss that finds the line Dirty also asserts `snp_supply`.
- R10: A snooped read-miss moves a Reserved line to Valid and leaves a Valid line Valid.
- R11: Only one bus transaction is outstanding at a time. `cpu_ready` is high for exactly one cycle, in the cycle after the request completes, and `bus_req` is low in that cycle.
- R12: Suppose a snoop takes the line while a request is waiting for the bus. A pending write that had been waiting to send its invalidate is reissued as a write-miss. A pending eviction of a Dirty line completes with no write-back.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request, held until `cpu_ready` |
| cpu_op | input | 2 | Request kind: 0 read, 1 write, 2 evict |
| cpu_ready | output | 1 | One-cycle completion pulse |
| line_st | output | 2 | Current coherence state of the line |
| bus_req | output | 1 | A bus transaction is requested |
| bus_cmd | output | 3 | Command of the requested transaction |
| bus_done | input | 1 | The requested transaction has completed |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 3 | Command of the snooped transaction |
| snp_supply | output | 1 | This cache must supply its Dirty data |

## Verification

The main function is driven by a scripted sequence of processor requests and snoops. It moves the line through every state and every transition, and both the bus command order and the final state are checked after each step. Reads, writes and evictions are tried from each starting state. This separates the bus-free hits from the misses, and the two-step first write from the later local writes. Snoops of each command are tried on Invalid, Valid, Reserved and Dirty lines. These tell downgrade, invalidation and data supply apart. Directed cases then insert a snoop while a request waits for the bus, which exposes whether the pending command is re-derived from the current line state.

// File: rtl/wo_coh_pkg.sv
package wo_coh_pkg;

    localparam int ST_W  = 2;
    localparam int OP_W  = 2;
    localparam int CMD_W = 3;

    typedef enum logic [ST_W-1:0] {
        LN_INV = 2'd0,
        LN_VAL = 2'd1,
        LN_RES = 2'd2,
        LN_DRT = 2'd3
    } line_st_e;

    typedef enum logic [OP_W-1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_EVICT = 2'd2,
        OP_NONE  = 2'd3
    } cpu_op_e;

    typedef enum logic [CMD_W-1:0] {
        BC_RD_MISS = 3'd0,
        BC_WR_MISS = 3'd1,
        BC_INVAL   = 3'd2,
        BC_WR_THRU = 3'd3,
        BC_WR_BACK = 3'd4
    } bus_cmd_e;

endpackage

// File: rtl/wo_snoop_resp.sv
module wo_snoop_resp
    import wo_coh_pkg::*;
(
    input  logic       snp_valid,
    input  bus_cmd_e   snp_cmd,
    input  line_st_e   cur_st,
    output logic       snp_upd,
    output line_st_e   snp_st,
    output logic       snp_supply
);
    always_comb begin
        snp_upd    = 1'b0;
        snp_st     = cur_st;
        snp_supply = 1'b0;
        if (snp_valid && cur_st != LN_INV) begin
            unique case (snp_cmd)
                BC_RD_MISS: begin
                    if (cur_st == LN_DRT || cur_st == LN_RES) begin
                        snp_upd    = 1'b1;
                        snp_st     = LN_VAL;
                        snp_supply = (cur_st == LN_DRT);
                    end
                end
                BC_WR_MISS: begin
                    snp_upd    = 1'b1;
                    snp_st     = LN_INV;
                    snp_supply = (cur_st == LN_DRT);
                end
                BC_INVAL, BC_WR_THRU: begin
                    snp_upd = 1'b1;
                    snp_st  = LN_INV;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/wo_line_reg.sv
module wo_line_reg
    import wo_coh_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     own_upd,
    input  line_st_e own_st,
    input  logic     snp_upd,
    input  line_st_e snp_st,
    output line_st_e cur_st
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_st <= LN_INV;
        else if (own_upd)
            cur_st <= own_st;
        else if (snp_upd)
            cur_st <= snp_st;
    end
endmodule

// File: rtl/wo_ctrl_fsm.sv
module wo_ctrl_fsm
    import wo_coh_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cpu_valid,
    input  cpu_op_e  cpu_op,
    input  line_st_e cur_st,
    input  logic     snp_valid,
    input  logic     bus_done,
    output logic     cpu_ready,
    output logic     bus_req,
    output bus_cmd_e bus_cmd,
    output logic     own_upd,
    output line_st_e own_st
);
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_THRU  = 2'd2,
        ST_ACK   = 2'd3
    } fsm_e;

    fsm_e    fsm_q, fsm_d;
    cpu_op_e op_q, op_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= ST_IDLE;
            op_q  <= OP_NONE;
        end else begin
            fsm_q <= fsm_d;
            op_q  <= op_d;
        end
    end

    always_comb begin
        fsm_d     = fsm_q;
        op_d      = op_q;
        cpu_ready = 1'b0;
        bus_req   = 1'b0;
        bus_cmd   = BC_RD_MISS;
        own_upd   = 1'b0;
        own_st    = cur_st;
        unique case (fsm_q)
            ST_IDLE: begin
                if (cpu_valid && !snp_valid) begin
                    op_d = cpu_op;
                    unique case (cpu_op)
                        OP_READ:
                            fsm_d = (cur_st == LN_INV) ? ST_ISSUE : ST_ACK;
                        OP_WRITE: begin
                            if (cur_st == LN_INV || cur_st == LN_VAL) begin
                                fsm_d = ST_ISSUE;
                            end else begin
                                own_upd = 1'b1;
                                own_st  = LN_DRT;
                                fsm_d   = ST_ACK;
                            end
                        end
                        OP_EVICT: begin
                            if (cur_st == LN_DRT) begin
                                fsm_d = ST_ISSUE;
                            end else begin
                                own_upd = 1'b1;
                                own_st  = LN_INV;
                                fsm_d   = ST_ACK;
                            end
                        end
                        default: fsm_d = ST_ACK;
                    endcase
                end
            end
            ST_ISSUE: begin
                unique case (op_q)
                    OP_READ: begin
                        if (cur_st == LN_INV) begin
                            bus_req = 1'b1;
                            bus_cmd = BC_RD_MISS;
                            if (bus_done) begin
                                own_upd = 1'b1;
                                own_st  = LN_VAL;
                                fsm_d   = ST_ACK;
                            end
                        end else if (!snp_valid) begin
                            fsm_d = ST_ACK;
                        end
                    end
                    OP_WRITE: begin
                        if (cur_st == LN_INV) begin
                            bus_req = 1'b1;
                            bus_cmd = BC_WR_MISS;
                            if (bus_done) begin
                                own_upd = 1'b1;
                                own_st  = LN_DRT;
                                fsm_d   = ST_ACK;
                            end
                        end else if (cur_st == LN_VAL) begin
                            bus_req = 1'b1;
                            bus_cmd = BC_INVAL;
                            if (bus_done)
                                fsm_d = ST_THRU;
                        end else if (!snp_valid) begin
                            own_upd = 1'b1;
                            own_st  = LN_DRT;
                            fsm_d   = ST_ACK;
                        end
                    end
                    OP_EVICT: begin
                        if (cur_st == LN_DRT) begin
                            bus_req = 1'b1;
                            bus_cmd = BC_WR_BACK;
                            if (bus_done) begin
                                own_upd = 1'b1;
                                own_st  = LN_INV;
                                fsm_d   = ST_ACK;
                            end
                        end else if (!snp_valid) begin
                            own_upd = 1'b1;
                            own_st  = LN_INV;
                            fsm_d   = ST_ACK;
                        end
                    end
                    default: fsm_d = ST_ACK;
                endcase
            end
            ST_THRU: begin
                if (cur_st == LN_INV) begin
                    fsm_d = ST_ISSUE;
                end else begin
                    bus_req = 1'b1;
                    bus_cmd = BC_WR_THRU;
                    if (bus_done) begin
                        own_upd = 1'b1;
                        own_st  = LN_RES;
                        fsm_d   = ST_ACK;
                    end
                end
            end
            ST_ACK: begin
                cpu_ready = 1'b1;
                fsm_d     = ST_IDLE;
            end
            default: fsm_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/wo_coherence_ctrl.sv
module wo_coherence_ctrl
    import wo_coh_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_valid,
    input  logic [OP_W-1:0]  cpu_op,
    output logic             cpu_ready,
    output logic [ST_W-1:0]  line_st,
    output logic             bus_req,
    output logic [CMD_W-1:0] bus_cmd,
    input  logic             bus_done,
    input  logic             snp_valid,
    input  logic [CMD_W-1:0] snp_cmd,
    output logic             snp_supply
);
    line_st_e cur_st;
    line_st_e own_st;
    line_st_e snp_st;
    logic     own_upd;
    logic     snp_upd;
    bus_cmd_e bus_cmd_e_w;

    wo_snoop_resp u_snoop (
        .snp_valid  (snp_valid),
        .snp_cmd    (bus_cmd_e'(snp_cmd)),
        .cur_st     (cur_st),
        .snp_upd    (snp_upd),
        .snp_st     (snp_st),
        .snp_supply (snp_supply)
    );

    wo_line_reg u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .own_upd (own_upd),
        .own_st  (own_st),
        .snp_upd (snp_upd),
        .snp_st  (snp_st),
        .cur_st  (cur_st)
    );

    wo_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_valid (cpu_valid),
        .cpu_op    (cpu_op_e'(cpu_op)),
        .cur_st    (cur_st),
        .snp_valid (snp_valid),
        .bus_done  (bus_done),
        .cpu_ready (cpu_ready),
        .bus_req   (bus_req),
        .bus_cmd   (bus_cmd_e_w),
        .own_upd   (own_upd),
        .own_st    (own_st)
    );

    assign line_st = cur_st;
    assign bus_cmd = bus_cmd_e_w;
endmodule

// File: rtl/wo_coh_checker.sv
module wo_coh_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_valid,
    input logic [1:0] cpu_op,
    input logic       cpu_ready,
    input logic [1:0] line_st,
    input logic       bus_req,
    input logic [2:0] bus_cmd,
    input logic       bus_done,
    input logic       snp_valid,
    input logic [2:0] snp_cmd,
    input logic       snp_supply
);
    p_read_hit_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_op == 2'd0 && line_st != 2'd0 && !snp_valid && !bus_req && !cpu_ready)
        |=> (line_st == $past(line_st) && !bus_req));

    p_rdmiss_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == 3'd0 && bus_done) |=> line_st == 2'd1);

    p_snoop_dirty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == 3'd0 && line_st == 2'd3 && !bus_done)
        |=> line_st == 2'd1);

    p_inval_then_thru_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == 3'd2 && bus_done) |=> (bus_req && bus_cmd == 3'd3));

    p_thru_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == 3'd3 && bus_done) |=> line_st == 2'd2);

    p_wrmiss_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == 3'd1 && bus_done) |=> line_st == 2'd3);

    p_wb_only_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == 3'd4) |-> line_st == 2'd3);

    p_snoop_kill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && (snp_cmd == 3'd1 || snp_cmd == 3'd2 || snp_cmd == 3'd3) && !bus_done)
        |=> line_st == 2'd0);

    p_supply_dirty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> (snp_valid && line_st == 2'd3));

    p_ready_no_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !bus_req);

    p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);
endmodule

bind wo_coherence_ctrl wo_coh_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_valid  (cpu_valid),
    .cpu_op     (cpu_op),
    .cpu_ready  (cpu_ready),
    .line_st    (line_st),
    .bus_req    (bus_req),
    .bus_cmd    (bus_cmd),
    .bus_done   (bus_done),
    .snp_valid  (snp_valid),
    .snp_cmd    (snp_cmd),
    .snp_supply (snp_supply)
);

// File: tb/wo_coherence_ctrl_test.sv
module wo_coherence_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;

    // vector: [14] kind (0 cpu, 1 snoop), [13:11] op or cmd,
    //         [10:3] expected bus command log, [2] expected supply, [1:0] expected state
    localparam logic [14:0] VEC [NVEC] = '{
        {1'b0, 3'd0, 8'd1,  1'b0, 2'd1},
        {1'b0, 3'd0, 8'd0,  1'b0, 2'd1},
        {1'b0, 3'd1, 8'd28, 1'b0, 2'd2},
        {1'b1, 3'd0, 8'd0,  1'b0, 2'd1},
        {1'b0, 3'd1, 8'd28, 1'b0, 2'd2},
        {1'b0, 3'd1, 8'd0,  1'b0, 2'd3},
        {1'b0, 3'd1, 8'd0,  1'b0, 2'd3},
        {1'b1, 3'd0, 8'd0,  1'b1, 2'd1},
        {1'b1, 3'd2, 8'd0,  1'b0, 2'd0},
        {1'b0, 3'd1, 8'd2,  1'b0, 2'd3},
        {1'b1, 3'd1, 8'd0,  1'b1, 2'd0},
        {1'b0, 3'd1, 8'd2,  1'b0, 2'd3},
        {1'b0, 3'd2, 8'd5,  1'b0, 2'd0},
        {1'b0, 3'd0, 8'd1,  1'b0, 2'd1},
        {1'b1, 3'd0, 8'd0,  1'b0, 2'd1},
        {1'b0, 3'd2, 8'd0,  1'b0, 2'd0},
        {1'b1, 3'd3, 8'd0,  1'b0, 2'd0},
        {1'b0, 3'd0, 8'd1,  1'b0, 2'd1},
        {1'b1, 3'd3, 8'd0,  1'b0, 2'd0},
        {1'b0, 3'd1, 8'd2,  1'b0, 2'd3}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_valid = 1'b0;
    logic [1:0] cpu_op = 2'd0;
    logic       cpu_ready;
    logic [1:0] line_st;
    logic       bus_req;
    logic [2:0] bus_cmd;
    logic       bus_done = 1'b0;
    logic       snp_valid = 1'b0;
    logic [2:0] snp_cmd = 3'd0;
    logic       snp_supply;

    int  n_tests = 0;
    int  n_fail  = 0;
    logic ended  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wo_coherence_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_op(cpu_op),
        .cpu_ready(cpu_ready), .line_st(line_st), .bus_req(bus_req),
        .bus_cmd(bus_cmd), .bus_done(bus_done), .snp_valid(snp_valid),
        .snp_cmd(snp_cmd), .snp_supply(snp_supply)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    function automatic string tag_of(input logic [14:0] v);
        if (v[14]) begin
            if (v[13:11] == 3'd0) return v[2] ? "R4" : "R10";
            return "R9";
        end
        case (v[13:11])
            3'd0: return (v[10:3] == 8'd0) ? "R2" : "R3";
            3'd1: return (v[10:3] == 8'd28) ? "R5" : ((v[10:3] == 8'd2) ? "R7" : "R6");
            default: return "R8";
        endcase
    endfunction

    // issues one processor request, answers each bus request, logs commands
    task automatic run_cpu(input logic [1:0] op, output logic [7:0] log, output logic ok);
        log = 8'd0;
        ok  = 1'b0;
        @(negedge clk);
        cpu_valid = 1'b1;
        cpu_op    = op;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            bus_done = 1'b0;
            if (cpu_ready) begin
                cpu_valid = 1'b0;
                ok = 1'b1;
                break;
            end
            if (bus_req) begin
                log = {log[4:0], bus_cmd + 3'd1};
                bus_done = 1'b1;
            end
        end
        cpu_valid = 1'b0;
        bus_done  = 1'b0;
    endtask

    task automatic run_snoop(input logic [2:0] cmd, output logic sup);
        @(negedge clk);
        snp_valid = 1'b1;
        snp_cmd   = cmd;
        #1 sup = snp_supply;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] log;
        logic       ok;
        logic       sup;

        repeat (3) @(negedge clk);
        check("R1", "state after reset", line_st, 0);
        check("R1", "bus_req after reset", bus_req, 0);
        check("R1", "cpu_ready after reset", cpu_ready, 0);
        rst_n = 1'b1;

        for (int k = 0; k < NVEC; k++) begin
            if (!VEC[k][14]) begin
                run_cpu(VEC[k][12:11], log, ok);
                check("R11", "request completed", ok, 1);
                check(tag_of(VEC[k]), "bus command log", log, VEC[k][10:3]);
            end else begin
                run_snoop(VEC[k][13:11], sup);
                check(tag_of(VEC[k]), "snoop supply", sup, VEC[k][2]);
            end
            check(tag_of(VEC[k]), "line state", line_st, VEC[k][1:0]);
        end

        // R11: ready is a single pulse with no bus request beside it
        @(negedge clk);
        cpu_valid = 1'b1; cpu_op = 2'd0;
        @(negedge clk);
        check("R11", "ready one cycle after hit", cpu_ready, 1);
        check("R11", "no bus request with ready", bus_req, 0);
        cpu_valid = 1'b0;
        @(negedge clk);
        check("R11", "ready drops after one cycle", cpu_ready, 0);

        // R12: pending write loses the line before its invalidate is granted
        run_snoop(3'd0, sup);
        check("R12", "setup state Valid", line_st, 1);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_op = 2'd1;
        @(negedge clk);
        check("R12", "first command invalidate", bus_cmd, 2);
        snp_valid = 1'b1; snp_cmd = 3'd2;
        @(negedge clk);
        snp_valid = 1'b0;
        check("R12", "line lost to snoop", line_st, 0);
        check("R12", "request still pending", bus_req, 1);
        check("R12", "reissued as write-miss", bus_cmd, 1);
        bus_done = 1'b1;
        @(negedge clk);
        bus_done = 1'b0;
        check("R12", "ready after write-miss", cpu_ready, 1);
        check("R12", "state Dirty after reissue", line_st, 3);
        cpu_valid = 1'b0;

        // R12: pending dirty eviction loses the line to a snooped read-miss
        @(negedge clk);
        cpu_valid = 1'b1; cpu_op = 2'd2;
        @(negedge clk);
        check("R8", "write-back requested", bus_cmd, 4);
        snp_valid = 1'b1; snp_cmd = 3'd0;
        #1 check("R4", "supply during pending evict", snp_supply, 1);
        @(negedge clk);
        snp_valid = 1'b0;
        check("R12", "line now Valid", line_st, 1);
        check("R12", "write-back withdrawn", bus_req, 0);
        @(negedge clk);
        check("R12", "eviction completes", cpu_ready, 1);
        check("R12", "line Invalid after evict", line_st, 0);
        cpu_valid = 1'b0;

        // R1: reset from a Dirty line
        run_cpu(2'd1, log, ok);
        check("R7", "write-miss before reset", line_st, 3);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "state after mid-run reset", line_st, 0);
        rst_n = 1'b1;

        finish_run();
    end
endmodule